// File: doc/BRIEF.md
# Four-Phase Handshake Word Receiver

This block is the receiving end of a return-to-zero request/ready handshake. It takes one word at a time from a producer that may run far slower than the local clock, for example an operator setting switches and flipping a ready switch. A start pulse from local logic makes the block raise its request output. The producer then puts a word on the data lines and raises ready. The block stores the word in an enabled register, drops request, and signals completion with a single-cycle done pulse. It accepts no new request until the producer has lowered ready again.

The ready line and the data lines come from outside the clock domain. Each passes through a two-stage synchronizer. The data is stored only when the synchronized ready is seen high. By that time the producer has held the data steady for at least two clock periods, so the captured word is settled. Debouncing of mechanical inputs and any processing of the word are left to other logic.

Top module: `hs_word_receiver`

## Requirements
- R1: A synchronous active-high reset leaves req low, done low and word_out at zero, with the block idle.
- R2: A start pulse seen while the block is idle and the synchronized ready is low makes req high from the next clock edge on. req then stays high until a word is captured.
- R3: If start arrives while the synchronized ready is still high, the start is ignored: req stays low. A later start, given after ready has been low for at least two clocks, raises req.
- R4: When ready rises while req is high, word_out takes the value on data_in at the third rising clock edge after the rise. This accounts for two synchronizer stages and one capture stage.
- R5: req falls on the same clock edge at which done rises.
- R6: done is high for exactly one clock per captured word, and only after req was high.
- R7: After a capture, req stays low as long as ready is high, even if start is pulsed during that time.
- R8: data_in changes that happen outside the capture edge leave word_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one word (acted on only when idle) |
| rdy_in | input | 1 | Producer ready, asynchronous |
| data_in | input | WIDTH | Producer data, asynchronous |
| req | output | 1 | Request to the producer |
| word_out | output | WIDTH | Last captured word |
| done | output | 1 | One-cycle pulse after a capture |

## Verification
The capture and the request release happen on the same edge. The bench measures both the done rise and the req fall relative to the ready rise, and expects both exactly three edges later. The clash of start with a ready line that is still high also needs its own tests. It is provoked in two ways: a start pulse before any request while ready is already up, and start pulses during the release phase. In both cases req must not rise.

// File: rtl/hs_word_receiver.sv
module hs_word_receiver #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rdy_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             req,
  output logic [WIDTH-1:0] word_out,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_DROP} state_t;

  state_t           state;
  logic [1:0]       rdy_pipe;
  logic [WIDTH-1:0] dat_q1, dat_q2;
  logic             rdy_sync;
  logic             take;

  assign rdy_sync = rdy_pipe[1];
  assign take     = (state == S_ASK) && rdy_sync;
  assign req      = (state == S_ASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_pipe <= '0;
      dat_q1   <= '0;
      dat_q2   <= '0;
    end else begin
      rdy_pipe <= {rdy_pipe[0], rdy_in};
      dat_q1   <= data_in;
      dat_q2   <= dat_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      word_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= take;
      if (take) word_out <= dat_q2;
      unique case (state)
        S_IDLE: if (start && !rdy_sync) state <= S_ASK;
        S_ASK:  if (rdy_sync) state <= S_DROP;
        S_DROP: if (!rdy_sync) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module hs_word_receiver_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             done,
  input logic             rdy_sync,
  input logic [WIDTH-1:0] word_out
);

  assert_drop_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> done);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(req));

  assert_raise_needs_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !$past(rdy_sync));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(word_out));

  assert_no_raise_while_high_R7: assert property (@(posedge clk) disable iff (rst)
    (!req && rdy_sync) |=> !req);

endmodule

bind hs_word_receiver hs_word_receiver_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .req(req), .done(done),
  .rdy_sync(rdy_sync), .word_out(word_out)
);

// File: tb/hs_word_receiver_test.sv
module hs_word_receiver_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         rdy_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         req, done;
  logic [W-1:0] word_out;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] last_word = '0;

  hs_word_receiver #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start), .rdy_in(rdy_in),
    .data_in(data_in), .req(req), .word_out(word_out), .done(done)
  );

  always #2 clk = ~clk;

  function automatic int capture_latency();
    return 3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic txn(input logic [W-1:0] val, input int wait_c, input int hold_c, input bit poke);
    start = 1'b1; step(); start = 1'b0;
    chk("R2 req after start", req, 1);
    for (int i = 0; i < wait_c; i++) begin
      step(); chk("R2 req held", req, 1); chk("R6 no early done", done, 0);
    end
    data_in = val; rdy_in = 1'b1;
    for (int k = 1; k <= capture_latency(); k++) begin
      step();
      if (k < capture_latency()) chk("R4 still waiting", req, 1);
    end
    chk("R5 req low at capture", req, 0);
    chk("R5 done with capture", done, 1);
    chk("R4 word", word_out, val);
    last_word = val;
    data_in = W'($urandom);
    step();
    chk("R6 done one cycle", done, 0);
    for (int i = 0; i < hold_c; i++) begin
      if (poke) start = 1'b1;
      step(); start = 1'b0;
      chk("R7 req stays low", req, 0);
      data_in = W'($urandom);
    end
    step(); start = 1'b0; chk("R7 req low", req, 0);
    rdy_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      data_in = W'($urandom); step();
      chk("R8 word unchanged", word_out, last_word);
      chk("R8 no done", done, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    chk("R1 req", req, 0); chk("R1 done", done, 0); chk("R1 word", word_out, 0);
    rst = 1'b0;
    step();
    txn(8'hA5, 0, 0, 0);
    txn(8'h00, 3, 2, 1);
    txn(8'hFF, 1, 5, 1);
    rdy_in = 1'b1; repeat (3) step();
    start = 1'b1; step(); start = 1'b0;
    for (int i = 0; i < 4; i++) begin step(); chk("R3 start ignored", req, 0); end
    rdy_in = 1'b0; repeat (3) step();
    chk("R3 still idle", req, 0);
    txn(8'h3C, 2, 1, 0);
    for (int n = 0; n < 40; n++)
      txn(W'($urandom), int'($urandom_range(0, 6)), int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)));
    rst = 1'b1; step(); step();
    chk("R1 word after reset", word_out, 0); chk("R1 req after reset", req, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule